// File: doc/BRIEF.md
# FIFO with reset-loaded half-full offset

This block is a first-in first-out word buffer, 9 bits wide, that reports its fill level on four active-low status pins: full, empty, a fixed half-full mark and a second mark whose threshold software chooses. The capacity is `2**ADDR_W` words. The default of `ADDR_W = 11` gives 2048 words, and a build with `ADDR_W = 14` gives the 16384-word part. Words enter through a valid/ready write port and leave through a valid/ready read port. Everything runs on one clock, and a transfer happens on each rising edge where valid and ready are both high on that side. A producer that sees `wr_ready` low must hold its word, because it was not taken. A consumer that drops `rd_ready` leaves the head word in place. Reads and writes in the same cycle are allowed, and together they leave the level unchanged.

The programmable threshold can only be written while the synchronous active-low reset is held. In that time, any edge that sees `wr_valid` or `rd_ready` high captures `wr_data` as a 9-bit offset field. The threshold in words is the field times `2**(ADDR_W-9)`. A reset period with no such strobe puts back the default field of 256, which is half the capacity. After reset is released, the field keeps its value until the next reset.

`exp_in` selects what the shared output `exp_out_hf` does. When `exp_in` is low, the block stands alone and the pin repeats the half-full mark. When `exp_in` is high, the block is one stage in a chain of buffers that extends the total depth. In that mode the pin marks each wrap of the write address with a one-cycle low pulse.

Top module: `prog_hf_fifo`

## Requirements
- R1: `full_n` is low exactly when the buffer holds `2**ADDR_W` words. After reset with no reads, that happens after exactly that many accepted writes. While full, `wr_ready` is low and a presented write is dropped.
- R2: `empty_n` is low exactly when no word is held. While empty, `rd_valid` is low and a presented read removes nothing.
- R3: Words leave in the order they were accepted. A cycle with both a write and a read accepted leaves the level unchanged.
- R4: `rd_data` is all zeros unless `rd_ready` and `rd_valid` are both high. When both are high, it shows the oldest held word.
- R5: While `rst_n` is low, each clock edge empties the buffer. Reset drives `empty_n` low and drives `full_n`, `half_n` and `phalf_n` high. During reset, `wr_ready` and `rd_valid` are low and no word moves.
- R6: During reset, any edge with `wr_valid` or `rd_ready` high loads `wr_data[8:0]` into the offset field, and the last such edge wins. The field is not changed outside reset.
- R7: A reset period with no load strobe leaves the field at 256, which sets the threshold to half the capacity.
- R8: `phalf_n` is low exactly when the level is greater than the field times `2**(ADDR_W-9)`.
- R9: `half_n` is low exactly when the level is greater than `2**(ADDR_W-1)`.
- R10: With `exp_in` low, `exp_out_hf` equals `half_n`.
- R11: With `exp_in` high, `exp_out_hf` stays high except for one cycle. That cycle follows each edge that writes into address `2**ADDR_W-1`, and in it the pin is low. The write address starts at 0 after reset and wraps, so the pulses come every `2**ADDR_W` accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; also the offset load window |
| wr_valid | input | 1 | Write word offered; offset load strobe during reset |
| wr_ready | output | 1 | Write will be taken on the next edge |
| wr_data | input | 9 | Write word; offset field during reset |
| rd_valid | output | 1 | A word is available to read |
| rd_ready | input | 1 | Consumer takes the head word; offset load strobe during reset |
| rd_data | output | 9 | Head word, or zeros when output-disabled |
| exp_in | input | 1 | 0 = single device, 1 = chained depth expansion |
| full_n | output | 1 | Full, active low |
| empty_n | output | 1 | Empty, active low |
| half_n | output | 1 | Level above half capacity, active low |
| phalf_n | output | 1 | Level above programmed threshold, active low |
| exp_out_hf | output | 1 | Half-full mirror, or one-cycle wrap pulse in expansion mode |

## Verification
The assertions assume that `wr_valid`, `rd_ready` and `exp_in` are sampled levels that are steady around each clock edge. They also assume that reset is held for at least one edge before the first transfer, so the pointers and the wrap pulse start from a known value. The stimulus drives every input only on the falling clock edge. It changes `exp_in` only between test phases, just before a reset period. It applies offset strobes only inside reset windows, so the rule that the threshold stays frozen outside reset always has a settled threshold to compare against.

// File: rtl/phf_pkg.sv
package phf_pkg;

  localparam int OFFSET_W_DEF = 9;

  typedef struct packed {
    logic above_half;
    logic above_thresh;
    logic wrap_pulse;
  } lvl_mark_t;

endpackage

// File: rtl/phf_ptr_ctl.sv
module phf_ptr_ctl #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   level,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] wptr_q;
  logic [PTR_W-1:0] rptr_q;

  always_comb begin
    full    = (wptr_q[ADDR_W] != rptr_q[ADDR_W]) &&
              (wptr_q[ADDR_W-1:0] == rptr_q[ADDR_W-1:0]);
    empty   = (wptr_q == rptr_q);
    wr_fire = rst_n && wr_req && !full;
    rd_fire = rst_n && rd_req && !empty;
    level   = wptr_q - rptr_q;
    waddr   = wptr_q[ADDR_W-1:0];
    raddr   = rptr_q[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_fire) wptr_q <= wptr_q + 1'b1;
      if (rd_fire) rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/phf_store.sv
module phf_store #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) mem_q[waddr] <= wr_word;
  end

  assign rd_word = mem_q[raddr];
endmodule

// File: rtl/phf_thresh.sv
module phf_thresh #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = phf_pkg::OFFSET_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic [OFF_W-1:0] load_word,
  output logic [ADDR_W:0]  thresh
);
  localparam int SH = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] FIELD_DEF = {1'b1, {(OFF_W-1){1'b0}}};

  logic [OFF_W-1:0] field_q;
  logic             taken_q;

  // taken_q marks that the current reset period has already seen a load
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (load_stb) begin
        field_q <= load_word;
        taken_q <= 1'b1;
      end else if (taken_q) begin
        field_q <= field_q;
      end else begin
        field_q <= FIELD_DEF;
      end
    end else begin
      taken_q <= 1'b0;
    end
  end

  generate
    if (SH == 0) begin : g_direct
      assign thresh = {1'b0, field_q};
    end else begin : g_scaled
      assign thresh = {1'b0, field_q, {SH{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/phf_flags.sv
module phf_flags #(
  parameter int ADDR_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W:0]    level,
  input  logic [ADDR_W:0]    thresh,
  input  logic               wr_fire,
  input  logic [ADDR_W-1:0]  waddr,
  output phf_pkg::lvl_mark_t marks
);
  localparam logic [ADDR_W:0] HALF = (ADDR_W+1)'(1) << (ADDR_W - 1);

  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= wr_fire && (&waddr);
  end

  always_comb begin
    marks.above_half   = (level > HALF);
    marks.above_thresh = (level > thresh);
    marks.wrap_pulse   = pulse_q;
  end
endmodule

// File: rtl/prog_hf_fifo.sv
module prog_hf_fifo #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 11,
  parameter int OFF_W  = phf_pkg::OFFSET_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              exp_in,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_n,
  output logic              phalf_n,
  output logic              exp_out_hf
);
  logic              wr_fire;
  logic              rd_fire;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [ADDR_W:0]   level;
  logic [ADDR_W:0]   thresh;
  logic              full;
  logic              empty;
  logic [DATA_W-1:0] head_word;
  phf_pkg::lvl_mark_t marks;

  phf_ptr_ctl #(.ADDR_W(ADDR_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_valid), .rd_req(rd_ready),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .waddr(waddr), .raddr(raddr),
    .level(level), .full(full), .empty(empty)
  );

  phf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .wr_fire(wr_fire), .waddr(waddr), .wr_word(wr_data),
    .raddr(raddr), .rd_word(head_word)
  );

  phf_thresh #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) thr_i (
    .clk(clk), .rst_n(rst_n), .load_stb(wr_valid || rd_ready),
    .load_word(wr_data[OFF_W-1:0]), .thresh(thresh)
  );

  phf_flags #(.ADDR_W(ADDR_W)) flg_i (
    .clk(clk), .rst_n(rst_n), .level(level), .thresh(thresh),
    .wr_fire(wr_fire), .waddr(waddr), .marks(marks)
  );

  always_comb begin
    wr_ready   = rst_n && !full;
    rd_valid   = rst_n && !empty;
    rd_data    = (rd_ready && rd_valid) ? head_word : '0;
    full_n     = !full;
    empty_n    = !empty;
    half_n     = !marks.above_half;
    phalf_n    = !marks.above_thresh;
    exp_out_hf = exp_in ? !marks.wrap_pulse : !marks.above_half;
  end
endmodule

// File: rtl/phf_fifo_chk.sv
module phf_fifo_chk #(
  parameter int ADDR_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            rd_ready,
  input logic            exp_in,
  input logic            full_n,
  input logic            empty_n,
  input logic            half_n,
  input logic            exp_out_hf,
  input logic [ADDR_W:0] level,
  input logic [ADDR_W:0] thresh
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(1) << ADDR_W;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) level <= CAP); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!full_n && wr_valid && !rd_ready) |=> !full_n); // R1
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!empty_n && !wr_valid) |=> !empty_n); // R2
  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !(!full_n && !empty_n)); // R2
  AST_FULL_ABOVE_HALF: assert property (@(posedge clk) disable iff (!rst_n) !full_n |-> !half_n); // R9
  AST_WRAP_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (exp_in && !exp_out_hf) |=> (exp_out_hf || !exp_in)); // R11
  AST_OFFSET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> $stable(thresh)); // R6
endmodule

bind prog_hf_fifo phf_fifo_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_ready(rd_ready),
  .exp_in(exp_in), .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
  .exp_out_hf(exp_out_hf), .level(level), .thresh(thresh)
);

// File: tb/prog_hf_fifo_tb_top.sv
`timescale 1ns/1ps
module prog_hf_fifo_tb_top;
  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SCALE  = 1 << (ADDR_W - 9);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid;
  logic       wr_ready;
  logic [8:0] wr_data;
  logic       rd_valid;
  logic       rd_ready;
  logic [8:0] rd_data;
  logic       exp_in;
  logic       full_n, empty_n, half_n, phalf_n, exp_out_hf;

  int vectors = 0;
  int miscompares = 0;
  bit checks_on = 0;
  string ptag = "R8";

  // behavioural reference state
  int q[$];
  int mfield = 256;
  bit mtaken = 0;
  int mwaddr = 0;
  bit mpulse = 0;

  always #2.5 clk = ~clk;

  prog_hf_fifo #(.DATA_W(9), .ADDR_W(ADDR_W), .OFF_W(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .exp_in(exp_in), .full_n(full_n), .empty_n(empty_n),
    .half_n(half_n), .phalf_n(phalf_n), .exp_out_hf(exp_out_hf)
  );

  always @(posedge clk) begin
    bit wf, rf;
    if (!rst_n) begin
      q.delete();
      mwaddr = 0;
      mpulse = 0;
      if (wr_valid || rd_ready) begin
        mfield = int'(wr_data);
        mtaken = 1;
      end else if (!mtaken) begin
        mfield = 256;
      end
    end else begin
      mtaken = 0;
      wf = wr_valid && (q.size() < DEPTH);
      rf = rd_ready && (q.size() > 0);
      if (rf) void'(q.pop_front());
      mpulse = wf && (mwaddr == DEPTH - 1);
      if (wf) begin
        q.push_back(int'(wr_data));
        mwaddr = (mwaddr + 1) % DEPTH;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int lvl;
    bit e_rv;
    int e_rd;
    bit e_half_n;
    lvl = q.size();
    e_rv = rst_n && (lvl > 0);
    e_rd = (rd_ready && e_rv) ? q[0] : 0;
    e_half_n = !(lvl > DEPTH / 2);
    if (!rst_n) begin
      chk("R5", "empty_n", int'(empty_n), 0);
      chk("R5", "full_n", int'(full_n), 1);
      chk("R5", "half_n", int'(half_n), 1);
      chk("R5", "phalf_n", int'(phalf_n), 1);
      chk("R5", "wr_ready", int'(wr_ready), 0);
      chk("R5", "rd_valid", int'(rd_valid), 0);
    end else begin
      chk("R1", "full_n", int'(full_n), int'(!(lvl == DEPTH)));
      chk("R1", "wr_ready", int'(wr_ready), int'(lvl < DEPTH));
      chk("R2", "empty_n", int'(empty_n), int'(!(lvl == 0)));
      chk("R2", "rd_valid", int'(rd_valid), int'(e_rv));
      chk("R9", "half_n", int'(half_n), int'(e_half_n));
      chk(ptag, "phalf_n", int'(phalf_n), int'(!(lvl > mfield * SCALE)));
      if (rd_ready) chk("R3", "rd_data", int'(rd_data), e_rd);
      else          chk("R4", "rd_data", int'(rd_data), e_rd);
      if (exp_in) chk("R11", "exp_out_hf", int'(exp_out_hf), int'(!mpulse));
      else        chk("R10", "exp_out_hf", int'(exp_out_hf), int'(e_half_n));
    end
  endtask

  task automatic step(input bit rs, input bit wv, input logic [8:0] wd, input bit rr);
    @(negedge clk);
    if (checks_on) check_all();
    rst_n    = rs;
    wr_valid = wv;
    wr_data  = wd;
    rd_ready = rr;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all requirements) act=hung exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_valid = 0; wr_data = '0; rd_ready = 0; exp_in = 0;
    @(posedge clk);
    checks_on = 1;
    // R5 / R7: plain reset, no load strobe
    for (int i = 0; i < 3; i++) step(0, 0, 9'd0, 0);
    ptag = "R7";
    // R1 / R9 / R7: fill past half, up to full, then push against full
    for (int i = 0; i < DEPTH + 4; i++) step(1, 1, 9'(i ^ 9'h0A5), 0);
    ptag = "R8";
    for (int i = 0; i < 6; i++) step(1, 1, 9'h1FF, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 9'd0, 0);
    // R2 / R3: drain and try reads while empty
    for (int i = 0; i < DEPTH + 10; i++) step(1, 0, 9'd0, 1);
    // R3 / R4: irregular traffic, first write-heavy then read-heavy
    for (int i = 0; i < 2500; i++) step(1, ($urandom % 4) != 0, 9'($urandom), ($urandom % 3) == 0);
    for (int i = 0; i < 2500; i++) step(1, ($urandom % 3) == 0, 9'($urandom), ($urandom % 4) != 0);
    // R6: load through the write strobe, field 100 -> threshold 400
    ptag = "R6";
    step(0, 1, 9'd100, 0);
    step(0, 0, 9'd3, 0);
    for (int i = 0; i < 450; i++) step(1, 1, 9'(i), 0);
    for (int i = 0; i < 20; i++) step(1, ($urandom % 2) == 0, 9'($urandom), 1);
    // R6: load through the read strobe then the write strobe; last wins (60 -> 240)
    step(0, 0, 9'd50, 1);
    step(0, 1, 9'd60, 0);
    step(0, 0, 9'd9, 0);
    for (int i = 0; i < 300; i++) step(1, 1, 9'(i * 3), 0);
    // R7: a reset without strobes restores the default threshold
    ptag = "R7";
    step(0, 0, 9'd0, 0);
    step(0, 0, 9'd0, 0);
    for (int i = 0; i < DEPTH / 2 + 8; i++) step(1, 1, 9'(i), 0);
    // R11: expansion mode, wrap pulses every DEPTH writes
    ptag = "R8";
    step(0, 0, 9'd0, 0);
    exp_in = 1;
    step(0, 0, 9'd0, 0);
    for (int i = 0; i < 2 * DEPTH + 20; i++) step(1, 1, 9'(i), i > 0);
    // R10: back to single mode, mirror of half_n
    step(0, 0, 9'd0, 0);
    exp_in = 0;
    step(0, 0, 9'd0, 0);
    for (int i = 0; i < DEPTH / 2 + 8; i++) step(1, 1, 9'(i), 0);
    for (int i = 0; i < 20; i++) step(1, 0, 9'd0, 1);
    step(1, 0, 9'd0, 0);
    finish_run();
  end
endmodule